// File: doc/BRIEF.md
# Sub-Scan Three-Line OR Density Halver

This block halves the line density of a binary image in the slow-scan (vertical) direction. Every output line stands for two input lines. It does not drop every other line. Each output pixel is the logical OR of the same column taken from three consecutive input lines. Adjacent output lines share their boundary input line, so a horizontal black stroke only one line thick is never lost. Black is encoded as 1.

Input pixels arrive one bit per beat on a valid/ready stream. The stream carries a line-start flag and a page-start flag. Lines are numbered from 0 at each page start. Output line k is the OR of input lines 2k-1, 2k and 2k+1. It is emitted beat for beat while input line 2k+1 streams in. Line -1 is taken as all white. Two banks of line storage hold the previous two lines. The parity of the current line selects which bank is overwritten and which bank is only read.

Back-pressure rules:
- On even lines nothing is emitted, and the input is always ready.
- On odd lines each input beat is passed straight to the output, so the input is ready exactly when the output is ready.

All lines of a page are assumed to share one length of at most LINE_MAX pixels. When a page has an odd number of lines, its last line produces no output.

Top module: `sscan_or_reducer`

## Requirements
- R1: On an odd line n ≥ 3 of a page, each output pixel equals the OR of the input pixels in the same column of lines n, n-1 and n-2.
- R2: Beats of even lines (line index 0, 2, 4, ... counted from the page start) produce no output beat. Every beat of an odd line produces exactly one output beat.
- R3: A black input pixel (1) on an odd line always gives a black output pixel.
- R4: On line 1 of a page, the output is the OR of lines 0 and 1 only. Pixels stored from an earlier page never reach the output.
- R5: On odd lines in_ready equals out_ready, and out_valid is high only while in_valid is high. At all other times in_ready is 1.
- R6: out_sol is 1 on the output beat that carries column 0 of an output line, and 0 on its other beats.
- R7: A beat with in_sop (sent together with in_sol) starts line 0, whatever the parity of the line before it. The first line started after reset is line 0 even without in_sop.
- R8: While reset is held and the input is idle, out_valid is 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Block accepts the input beat |
| in_pix | input | 1 | Input pixel, 1 = black |
| in_sol | input | 1 | Beat is column 0 of a line |
| in_sop | input | 1 | Beat is column 0 of line 0 of a page |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Sink accepts the output beat |
| out_pix | output | 1 | Output pixel, 1 = black |
| out_sol | output | 1 | Output beat is column 0 of an output line |

## Verification
The hardest case to reach is a page start that arrives while stale black content from the previous page still sits in the bank that line 1 would read as line -1, and arrives on a line that would otherwise be odd. The stimulus gets there in three ways:
- It runs dense black pages with an odd line count.
- It follows each with a sparse page, so any leak of old content shows up as an extra black pixel.
- It randomises output back-pressure during odd lines, so stalls land on the line-start and page-start beats themselves.

// File: rtl/sor_pkg.sv
package sor_pkg;
  typedef enum logic [1:0] {
    PH_L0    = 2'd0,
    PH_L1    = 2'd1,
    PH_LATER = 2'd2,
    PH_IDLE  = 2'd3
  } line_ph_e;
endpackage

// File: rtl/sor_line_bank.sv
module sor_line_bank #(
  parameter int DEPTH = 256,
  parameter int AW    = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic          wbit,
  output logic          rbit
);
  logic store [DEPTH];

  // read returns the old content; a write in the same cycle lands at the edge
  always_ff @(posedge clk) begin
    if (we) store[addr] <= wbit;
  end

  assign rbit = store[addr];
endmodule

// File: rtl/sor_line_seq.sv
module sor_line_seq
  import sor_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          beat,
  input  logic          sol,
  input  logic          sop,
  output logic          eff_odd,
  output logic          eff_early,
  output logic [AW-1:0] eff_col
);
  logic          par_q;
  line_ph_e      ph_q;
  logic [AW-1:0] col_q;
  line_ph_e      ph_d;
  logic          restart;

  assign restart = sop || (ph_q == PH_IDLE);

  always_comb begin
    ph_d = ph_q;
    if (sol) begin
      if (restart)                ph_d = PH_L0;
      else if (ph_q == PH_L0)     ph_d = PH_L1;
      else                        ph_d = PH_LATER;
    end
  end

  assign eff_odd   = sol ? (restart ? 1'b0 : ~par_q) : par_q;
  assign eff_col   = sol ? '0 : col_q;
  assign eff_early = (ph_d == PH_L0) || (ph_d == PH_L1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      par_q <= 1'b0;
      ph_q  <= PH_IDLE;
      col_q <= '0;
    end else if (beat) begin
      par_q <= eff_odd;
      ph_q  <= ph_d;
      col_q <= eff_col + 1'b1;
    end
  end
endmodule

// File: rtl/sor_or_merge.sv
module sor_or_merge (
  input  logic       eff_odd,
  input  logic       eff_early,
  input  logic [1:0] bank_rd,
  input  logic       pix,
  output logic       merged
);
  logic prev1, prev2;
  // bank written this line holds line n-2, the other holds line n-1
  assign prev1  = bank_rd[~eff_odd];
  assign prev2  = bank_rd[eff_odd] & ~eff_early;
  assign merged = pix | prev1 | prev2;
endmodule

// File: rtl/sscan_or_reducer.sv
module sscan_or_reducer #(
  parameter int LINE_MAX = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  output logic in_ready,
  input  logic in_pix,
  input  logic in_sol,
  input  logic in_sop,
  output logic out_valid,
  input  logic out_ready,
  output logic out_pix,
  output logic out_sol
);
  localparam int AW = (LINE_MAX > 1) ? $clog2(LINE_MAX) : 1;

  logic          sol_v, sop_v, fire;
  logic          eff_odd, eff_early;
  logic [AW-1:0] eff_col;
  logic [1:0]    bank_rd;

  assign sol_v = in_valid & in_sol;
  assign sop_v = in_valid & in_sop;

  sor_line_seq #(.AW(AW)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .beat     (fire),
    .sol      (sol_v),
    .sop      (sop_v),
    .eff_odd  (eff_odd),
    .eff_early(eff_early),
    .eff_col  (eff_col)
  );

  for (genvar b = 0; b < 2; b++) begin : g_bank
    localparam logic SEL = 1'(b);
    sor_line_bank #(.DEPTH(LINE_MAX), .AW(AW)) u_bank (
      .clk (clk),
      .we  (fire && (eff_odd == SEL)),
      .addr(eff_col),
      .wbit(in_pix),
      .rbit(bank_rd[b])
    );
  end

  sor_or_merge u_merge (
    .eff_odd  (eff_odd),
    .eff_early(eff_early),
    .bank_rd  (bank_rd),
    .pix      (in_pix),
    .merged   (out_pix)
  );

  assign in_ready  = ~eff_odd | out_ready;
  assign fire      = in_valid & in_ready;
  assign out_valid = in_valid & eff_odd;
  assign out_sol   = in_sol;
endmodule

// File: rtl/sscan_or_reducer_chk.sv
module sscan_or_reducer_chk (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_ready,
  input logic in_pix,
  input logic in_sol,
  input logic in_sop,
  input logic out_valid,
  input logic out_ready,
  input logic out_pix,
  input logic out_sol
);
  AST_SOP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sop) |-> !out_valid);                       // R7
  AST_SOP_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sop) |-> in_ready);                         // R5
  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);                   // R5
  AST_VALID_FROM_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> in_valid);                                    // R2
  AST_BLACK_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && in_pix) |-> out_pix);                         // R3
  AST_SOL_MARKED: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && in_sol) |-> out_sol);                         // R6
endmodule

bind sscan_or_reducer sscan_or_reducer_chk u_chk (.*);

// File: tb/test_sscan_or_reducer.sv
module test_sscan_or_reducer;
  localparam int LMAX = 256;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_pix = 1'b0, in_sol = 1'b0, in_sop = 1'b0;
  logic out_ready = 1'b1;
  logic in_ready, out_valid, out_pix, out_sol;

  int total = 0, bad = 0, cyc = 0, rdy_pct = 100;
  bit done = 0;

  // reference state
  int m_l = -1, m_col = 0;
  bit cur [LMAX];
  bit pv1 [LMAX];
  bit pv2 [LMAX];

  always #10 clk = ~clk;

  sscan_or_reducer #(.LINE_MAX(LMAX)) i_sscan_or_reducer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_pix(in_pix), .in_sol(in_sol), .in_sop(in_sop),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_pix(out_pix), .out_sol(out_sol)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d line=%0d col=%0d", req, act, exp, m_l, m_col);
    end
  endtask

  always @(posedge clk) begin
    if (!done) begin
      cyc++;
      if (cyc == 150000) begin
        bad++; total++;
        $display("FAIL watchdog act=%0d exp=0", cyc);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
      // back-pressure pattern
      #1 out_ready = ($urandom_range(99) < rdy_pct);
    end
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      if (!in_valid) begin
        chk(out_valid == 1'b0, "R8 out_valid", out_valid, 0);
        chk(in_ready == 1'b1, "R8 in_ready", in_ready, 1);
      end
    end else begin
      int e_l, e_c;
      bit p1, p2, odd, e_rdy, e_pix;
      if (in_valid && in_sol) begin
        e_l = (in_sop || m_l < 0) ? 0 : m_l + 1;
        e_c = 0;
        p1 = cur[0];
        p2 = pv1[0];
      end else begin
        e_l = m_l;
        e_c = m_col;
        p1 = pv1[e_c];
        p2 = pv2[e_c];
      end
      odd = (e_l >= 0) && (e_l % 2 == 1);
      e_rdy = odd ? out_ready : 1'b1;
      chk(in_ready == e_rdy, "R5 in_ready", in_ready, e_rdy);
      chk(out_valid == (in_valid && odd), in_sop ? "R7 out_valid" : "R2 out_valid",
          out_valid, in_valid && odd);
      if (in_valid && odd && out_valid) begin
        e_pix = in_pix | p1 | ((e_l >= 2) ? p2 : 1'b0);
        chk(out_pix == e_pix, (e_l == 1) ? "R4 out_pix" : (in_pix ? "R3 out_pix" : "R1 out_pix"),
            out_pix, e_pix);
        chk(out_sol == in_sol, "R6 out_sol", out_sol, in_sol);
      end
      if (in_valid && in_ready) begin
        if (in_sol) begin
          pv2 = pv1;
          pv1 = cur;
          m_l = e_l;
        end
        if (e_l >= 0) cur[e_c] = in_pix;
        m_col = e_c + 1;
      end
    end
  end

  task automatic push(input bit pix, input bit sol, input bit sop);
    if ($urandom_range(3) == 0) repeat ($urandom_range(2)) @(posedge clk);
    #1;
    in_valid = 1'b1; in_pix = pix; in_sol = sol; in_sop = sop;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1;
    in_valid = 1'b0; in_pix = 1'b0; in_sol = 1'b0; in_sop = 1'b0;
  endtask

  // mode 0 random density, 1 single black row at line 'row'
  task automatic page(input int w, input int lines, input int dens, input bit with_sop,
                      input int mode, input int row);
    for (int l = 0; l < lines; l++) begin
      for (int c = 0; c < w; c++) begin
        bit px;
        px = (mode == 1) ? (l == row) : ($urandom_range(99) < dens);
        push(px, c == 0, with_sop && (l == 0) && (c == 0));
      end
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R7: first line after reset without a page flag
    page(6, 4, 50, 1'b0, 0, 0);
    // R1 R3: thin rows on even and odd lines survive
    page(8, 6, 0, 1'b1, 1, 2);
    page(8, 6, 0, 1'b1, 1, 3);
    page(8, 6, 0, 1'b1, 1, 0);
    // R4 R7: dense odd-count page, then sparse page
    rdy_pct = 60;
    page(12, 5, 90, 1'b1, 0, 0);
    page(12, 4, 5, 1'b1, 0, 0);
    page(12, 7, 100, 1'b1, 0, 0);
    page(12, 3, 0, 1'b1, 0, 0);
    // R5 heavy back-pressure
    rdy_pct = 25;
    page(20, 6, 30, 1'b1, 0, 0);
    rdy_pct = 80;
    for (int p = 0; p < 6; p++) page(5 + p * 7, 3 + p, 10 + p * 15, 1'b1, 0, 0);
    // full-length lines
    rdy_pct = 90;
    page(LMAX, 4, 20, 1'b1, 0, 0);
    repeat (5) @(posedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule